// File: doc/BRIEF.md
# No-turnaround pipelined synchronous SRAM

This block models a single-clock synchronous SRAM whose read path is pipelined and whose write data arrives late. Every enabled clock edge can start a read or a write in any order, with no idle cycle between a read and a write. A read returns its word on the output one edge after the edge that sampled its address. The data for a write is taken from the data bus two enabled edges after its address, so the write's address and lane enables travel down a short pipeline. A read that meets a still-pending write to the same word sees that write's data, merged lane by lane.

The word is 36 bits in four 9-bit lanes (eight data bits and one parity bit each). The two low address bits seed a four-beat burst counter. Advance cycles step that counter in linear or interleaved order. A clock enable freezes the whole pipeline. Three chip selects must all be true before a new access is loaded. An asynchronous output enable gates the driven data.

Top module: `nts_sram`

## Requirements
- R1: A read loaded at enabled edge N drives its word on `dq` and sets `dq_en` after enabled edge N+1, as long as `oe` is high.
- R2: For a write loaded at enabled edge N, the data is taken from `din` at enabled edge N+2. Lane k is bits [9k+8:9k], and only lanes whose `lane_we[k]` bit (active high, sampled with the address) is 1 are updated. The other lanes keep their old contents.
- R3: A read issued in the enabled cycle right after a write to the same address returns the write's `din` in the written lanes and the old contents in the others, with no stall.
- R4: While `clk_en` is low, no state changes. The output word and `dq_en` hold, and `din`, the address and the controls are ignored.
- R5: A load cycle (`adv`=0) starts an access only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. Otherwise it is a deselect: no access starts, any burst ends, and `dq_en` is low one edge later.
- R6: An advance cycle (`adv`=1) during a burst ignores the chip selects, the address and `wr_sel`. It keeps the burst's read/write type and upper address bits, and steps the beat count by one. An advance with no burst open starts nothing.
- R7: With `ilv`=0, beat c of a burst seeded with low bits s uses low address bits (s+c) mod 4.
- R8: With `ilv`=1, beat c of a burst seeded with low bits s uses low address bits s XOR c.
- R9: `dq_en` is high exactly when `oe` is high and the output holds valid read data, and it follows `oe` with no clock. When `dq_en` is low, `dq` is high-impedance.
- R10: While reset is asserted, and after it is released, no read data is driven and no burst is open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; low suspends the cycle |
| addr | input | 8 | Word address of a load cycle |
| wr_sel | input | 1 | 1 selects write, 0 read, on a load cycle |
| lane_we | input | 4 | Per-lane write enables, active high |
| adv | input | 1 | 1 advances the burst, 0 loads a new address |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| oe | input | 1 | Asynchronous output enable, active high |
| ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| din | input | 36 | Write data bus |
| dq | output | 36 | Read data, high-impedance when not driven |
| dq_en | output | 1 | High while `dq` is driven |

## Verification
The assertions assume that `ilv` and `oe` are steady around each rising edge. They also assume that a read meeting a pending write refers to a word that has been written in full before, so that merged results are defined. The stimulus changes every input only at falling edges. It writes each word with all lanes enabled before any partial write or read of it. It reads only addresses it has written.

// File: rtl/nts_pkg.sv
package nts_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned DATA_W = LANES * LANE_W;

  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] old_w,
    input logic [DATA_W-1:0] new_w,
    input logic [LANES-1:0]  sel
  );
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int k = 0; k < LANES; k++)
      if (sel[k]) r[k*LANE_W +: LANE_W] = new_w[k*LANE_W +: LANE_W];
    return r;
  endfunction
endpackage

// File: rtl/nts_burst.sv
module nts_burst
  import nts_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_sel,
  input  logic [LANES-1:0]  lane_we,
  input  logic              adv,
  input  logic              cs_ok,
  input  logic              ilv,
  output logic              op_valid,
  output logic              op_wr,
  output logic [ADDR_W-1:0] op_addr,
  output logic [LANES-1:0]  op_be
);
  localparam int unsigned HI_W = ADDR_W - 2;

  logic [HI_W-1:0] b_hi, hi_n;
  logic [1:0]      b_seed, seed_n, b_cnt, cnt_n, low;
  logic            b_wr, wr_n, b_act, act_n;
  logic            load, step;

  always_comb begin
    load   = !adv && cs_ok;
    step   = adv && b_act;
    hi_n   = load ? addr[ADDR_W-1:2] : b_hi;
    seed_n = load ? addr[1:0] : b_seed;
    wr_n   = load ? wr_sel : b_wr;
    if (load)      cnt_n = 2'd0;
    else if (step) cnt_n = b_cnt + 2'd1;
    else           cnt_n = b_cnt;
    if (load)      act_n = 1'b1;
    else if (!adv) act_n = 1'b0;
    else           act_n = b_act;
    low      = ilv ? (seed_n ^ cnt_n) : (seed_n + cnt_n);
    op_valid = load || step;
    op_wr    = wr_n;
    op_addr  = {hi_n, low};
    op_be    = lane_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_hi   <= '0;
      b_seed <= '0;
      b_cnt  <= '0;
      b_wr   <= 1'b0;
      b_act  <= 1'b0;
    end else if (clk_en) begin
      b_hi   <= hi_n;
      b_seed <= seed_n;
      b_cnt  <= cnt_n;
      b_wr   <= wr_n;
      b_act  <= act_n;
    end
  end

  // R6
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv && b_act) |=> (b_cnt == $past(b_cnt) + 2'd1) && (b_hi == $past(b_hi)) && (b_wr == $past(b_wr)));

  // R5
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv && !cs_ok) |=> !b_act);
endmodule

// File: rtl/nts_array.sv
module nts_array
  import nts_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wbe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= lane_merge(mem[waddr], wdata, wbe);
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nts_datapath.sv
module nts_datapath
  import nts_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              op_valid,
  input  logic              op_wr,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [LANES-1:0]  op_be,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_q,
  output logic              rd_valid
);
  logic              sa_valid, sa_wr;
  logic [ADDR_W-1:0] sa_addr, wb_addr;
  logic [LANES-1:0]  sa_be, wb_be;
  logic              wb_valid;
  logic [DATA_W-1:0] arr_rd, rd_n;
  logic              rdv_n, fwd;

  nts_array #(.ADDR_W(ADDR_W)) i_array (
    .clk   (clk),
    .we    (clk_en && wb_valid),
    .waddr (wb_addr),
    .wbe   (wb_be),
    .wdata (din),
    .raddr (sa_addr),
    .rdata (arr_rd)
  );

  always_comb begin
    fwd   = wb_valid && (wb_addr == sa_addr);
    rdv_n = sa_valid && !sa_wr;
    rd_n  = rd_q;
    if (rdv_n) rd_n = fwd ? lane_merge(arr_rd, din, wb_be) : arr_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_valid <= 1'b0;
      sa_wr    <= 1'b0;
      sa_addr  <= '0;
      sa_be    <= '0;
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_be    <= '0;
      rd_q     <= '0;
      rd_valid <= 1'b0;
    end else if (clk_en) begin
      sa_valid <= op_valid;
      sa_wr    <= op_wr;
      sa_addr  <= op_addr;
      sa_be    <= op_be;
      wb_valid <= sa_valid && sa_wr;
      wb_addr  <= sa_addr;
      wb_be    <= sa_be;
      rd_q     <= rd_n;
      rd_valid <= rdv_n;
    end
  end

  // R4
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(rd_q) && $stable(rd_valid) && $stable(wb_valid) && $stable(sa_valid));

  // R1
  read_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sa_valid && !sa_wr) |=> rd_valid);

  // R2
  write_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sa_valid && sa_wr) |=> (wb_valid && wb_addr == $past(sa_addr) && wb_be == $past(sa_be)));

  // R3
  forward_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sa_valid && !sa_wr && wb_valid && wb_addr == sa_addr && wb_be == {LANES{1'b1}})
      |=> rd_q == $past(din));
endmodule

// File: rtl/nts_sram.sv
module nts_sram
  import nts_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_sel,
  input  logic [LANES-1:0]  lane_we,
  input  logic              adv,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              oe,
  input  logic              ilv,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq,
  output logic              dq_en
);
  logic              cs_ok, op_valid, op_wr, rd_valid;
  logic [ADDR_W-1:0] op_addr;
  logic [LANES-1:0]  op_be;
  logic [DATA_W-1:0] rd_q;

  assign cs_ok = !cs0_n && cs1 && !cs2_n;

  nts_burst #(.ADDR_W(ADDR_W)) i_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .addr     (addr),
    .wr_sel   (wr_sel),
    .lane_we  (lane_we),
    .adv      (adv),
    .cs_ok    (cs_ok),
    .ilv      (ilv),
    .op_valid (op_valid),
    .op_wr    (op_wr),
    .op_addr  (op_addr),
    .op_be    (op_be)
  );

  nts_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .op_valid (op_valid),
    .op_wr    (op_wr),
    .op_addr  (op_addr),
    .op_be    (op_be),
    .din      (din),
    .rd_q     (rd_q),
    .rd_valid (rd_valid)
  );

  assign dq_en = oe && rd_valid;
  assign dq    = dq_en ? rd_q : 'z;
endmodule

// File: tb/test_nts_sram.sv
module test_nts_sram;
  localparam int unsigned DW = 36;
  localparam logic [2:0] OK = 3'b010;  // {cs0_n, cs1, cs2_n}
  localparam logic [2:0] NO = 3'b000;
  localparam logic [DW-1:0] A  = 36'h111111111;
  localparam logic [DW-1:0] B  = 36'h222222222;
  localparam logic [DW-1:0] C  = 36'hFFFFFFFFF;
  localparam logic [DW-1:0] D0 = 36'h0A0A0A0A0;
  localparam logic [DW-1:0] D1 = 36'h1B1B1B1B1;
  localparam logic [DW-1:0] D2 = 36'h2C2C2C2C2;
  localparam logic [DW-1:0] D3 = 36'h3D3D3D3D3;
  localparam logic [DW-1:0] E  = 36'h5A5A5A5A5;

  function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o, input logic [DW-1:0] n, input logic [3:0] s);
    logic [DW-1:0] r;
    r = o;
    for (int k = 0; k < 4; k++) if (s[k]) r[k*9 +: 9] = n[k*9 +: 9];
    return r;
  endfunction

  typedef struct packed {
    logic          adv;
    logic [2:0]    cs;
    logic          wr;
    logic          il;
    logic [3:0]    be;
    logic [7:0]    ad;
    logic [DW-1:0] d;
    logic          een;
    logic [DW-1:0] edq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b0, OK, 1'b1, 1'b0, 4'hF, 8'h10, '0, 1'b0, '0},          // write 0x10
    '{1'b0, OK, 1'b1, 1'b0, 4'hF, 8'h20, '0, 1'b0, '0},          // write 0x20
    '{1'b0, OK, 1'b0, 1'b0, 4'hF, 8'h10, A,  1'b0, '0},          // R2 data for 0x10
    '{1'b0, OK, 1'b0, 1'b0, 4'hF, 8'h20, B,  1'b1, A},           // R1 read 0x10
    '{1'b0, OK, 1'b1, 1'b0, 4'h5, 8'h10, '0, 1'b1, B},           // partial write
    '{1'b0, OK, 1'b0, 1'b0, 4'hF, 8'h10, '0, 1'b0, '0},          // R3 back-to-back read
    '{1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, C,  1'b1, mrg(A, C, 4'h5)},
    '{1'b0, OK, 1'b1, 1'b0, 4'hF, 8'h40, '0, 1'b0, '0},          // R7 write burst
    '{1'b1, OK, 1'b0, 1'b0, 4'hF, 8'h00, '0, 1'b0, '0},          // R6 type kept
    '{1'b1, OK, 1'b0, 1'b0, 4'hF, 8'h00, D0, 1'b0, '0},
    '{1'b1, OK, 1'b0, 1'b0, 4'hF, 8'h00, D1, 1'b0, '0},
    '{1'b0, OK, 1'b0, 1'b1, 4'hF, 8'h41, D2, 1'b0, '0},          // R8 read burst seed 1
    '{1'b1, OK, 1'b1, 1'b1, 4'hF, 8'h00, D3, 1'b1, D1},
    '{1'b1, NO, 1'b1, 1'b1, 4'hF, 8'h00, '0, 1'b1, D0},          // R6 selects ignored
    '{1'b1, OK, 1'b0, 1'b1, 4'hF, 8'h00, '0, 1'b1, D3},
    '{1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, '0, 1'b1, D2},          // R5 deselect
    '{1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, '0, 1'b0, '0}
  };

  logic clk = 1'b0;
  logic rst_n, clk_en, wr_sel, adv, cs0_n, cs1, cs2_n, oe, ilv;
  logic [7:0] addr;
  logic [3:0] lane_we;
  logic [DW-1:0] din, dq;
  logic dq_en;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nts_sram i_nts_sram (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr), .wr_sel(wr_sel),
    .lane_we(lane_we), .adv(adv), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .oe(oe), .ilv(ilv), .din(din), .dq(dq), .dq_en(dq_en)
  );

  task automatic chk(input string tag, input logic en_e, input logic [DW-1:0] dq_e);
    checks++;
    if (dq_en !== en_e || (en_e && dq !== dq_e)) begin
      errors++;
      $display("FAIL %s: dq_en=%0b dq=%h expected dq_en=%0b dq=%h", tag, dq_en, dq, en_e, dq_e);
    end
  endtask

  task automatic cyc(input logic a, input logic [2:0] c, input logic w, input logic il,
                     input logic [3:0] b, input logic [7:0] ad, input logic [DW-1:0] d);
    adv = a; {cs0_n, cs1, cs2_n} = c; wr_sel = w; ilv = il; lane_we = b; addr = ad; din = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_en = 1'b1; oe = 1'b1;
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, '0);
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, '0);
    chk("R10 in reset", 1'b0, '0);
    rst_n = 1'b1;
    cyc(1'b1, OK, 1'b0, 1'b0, 4'hF, 8'h00, '0);   // R6 advance with no burst
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, '0);
    chk("R10 after reset, R6 idle advance", 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i].adv, TBL[i].cs, TBL[i].wr, TBL[i].il, TBL[i].be, TBL[i].ad, TBL[i].d);
      chk($sformatf("R1 R2 R3 R5 R6 R7 R8 table row %0d", i), TBL[i].een, TBL[i].edq);
    end

    // R4 read held during suspend
    cyc(1'b0, OK, 1'b0, 1'b0, 4'hF, 8'h40, '0);
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, '0);
    chk("R4 before suspend", 1'b1, D0);
    clk_en = 1'b0;
    for (int j = 0; j < 3; j++) begin
      cyc(1'b0, OK, 1'b0, 1'b0, 4'hF, 8'h41, E);
      chk("R4 output held", 1'b1, D0);
    end
    clk_en = 1'b1;
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, '0);
    chk("R4 suspended read ignored", 1'b0, '0);

    // R4 write data counted in enabled edges
    cyc(1'b0, OK, 1'b1, 1'b0, 4'hF, 8'h60, '0);
    clk_en = 1'b0;
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, C);
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, C);
    clk_en = 1'b1;
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, C);
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, E);
    cyc(1'b0, OK, 1'b0, 1'b0, 4'hF, 8'h60, '0);
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, '0);
    chk("R4 R2 write across suspend", 1'b1, E);

    // R7 linear read burst seeded at 3: 43,40,41,42
    cyc(1'b0, OK, 1'b0, 1'b0, 4'hF, 8'h43, '0);
    cyc(1'b1, OK, 1'b0, 1'b0, 4'hF, 8'h00, '0);
    chk("R7 beat0", 1'b1, D3);
    cyc(1'b1, OK, 1'b0, 1'b0, 4'hF, 8'h00, '0);
    chk("R7 beat1", 1'b1, D0);
    cyc(1'b1, OK, 1'b0, 1'b0, 4'hF, 8'h00, '0);
    chk("R7 beat2", 1'b1, D1);
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, '0);
    chk("R7 beat3", 1'b1, D2);

    // R9 output enable without a clock edge
    #2 oe = 1'b0; #1;
    chk("R9 oe low", 1'b0, '0);
    oe = 1'b1; #1;
    chk("R9 oe high", 1'b1, D2);
    @(negedge clk);

    // R5 each chip select false on its own
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, OK ^ (3'b001 << k), 1'b0, 1'b0, 4'hF, 8'h40, '0);
      cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, '0);
      chk($sformatf("R5 select %0d false", k), 1'b0, '0);
    end

    // R10 reset drops a pending read
    cyc(1'b0, OK, 1'b0, 1'b0, 4'hF, 8'h40, '0);
    rst_n = 1'b0; #1;
    chk("R10 reset mid read", 1'b0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, NO, 1'b0, 1'b0, 4'hF, 8'h00, '0);
    chk("R10 after mid reset", 1'b0, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule